// File: doc/BRIEF.md
# Multi-Width Packed-Field Arithmetic Unit

This block is a single-cycle datapath for SIMD-within-a-register work. It takes two N-bit operand words, plus a third word that only the bitwise select uses. It treats the words as rows of equal fields 2, 4, 8, 16 or 32 bits wide and writes one N-bit result word. The opcode names the operation and the field width. It also carries one modifier for each of the first two operands. Each modifier can swap every field for its upper half or its lower half, right-aligned and zero-extended, or leave the field as it is, before the operation runs.

The operations are field add, field subtract, field shift-left and field rotate-left, with the count taken from the matching field of the second operand. There is also a bitwise select, a pack that halves the field width, and two merges that double it. The result and an error flag are registered one cycle after a valid request. An opcode that names no supported combination produces a zero result with the error flag set. N is a power of two and at least 64, so that 32-bit fields can still be merged.

Top module: `swar_alu`

## Requirements
- R1: For add, each field i of the result equals (A_i + B_i) mod 2^n, where n is the selected field width and field i occupies bits [i*n +: n]. No carry passes between fields.
- R2: For subtract, each result field equals (A_i - B_i + 2^n) mod 2^n.
- R3: For shift-left, each result field equals A_i * 2^(B_i mod n) mod 2^n, so every field uses its own count.
- R4: For rotate-left, each field of A is rotated left by (B_i mod n) places within its own n bits.
- R5: For select, the result is (A AND B) OR (NOT A AND C). Modifiers apply to A and B only, and C is used as given.
- R6: Modifier codes are 0 = unchanged, 1 = upper n/2 bits of the field moved down with zero fill, 2 = lower n/2 bits with zero fill. They apply to the operand feeding every operation.
- R7: Pack at width n writes n/2-bit fields. The lower n/2 bits of modified A field i go to bits [N/2 + i*n/2 +: n/2], and those of modified B field i go to bits [i*n/2 +: n/2].
- R8: Merge-high (op 6) sets result field k of width 2n to {A_j, B_j} with j = k + N/(2n). Merge-low (op 7) does the same with j = k. In both, A sits in the upper n bits of the wider field.
- R9: The opcode is 11 bits: op[10:7], width code [6:4] with field width = 2^code for codes 1 to 5, A modifier [3:2], B modifier [1:0]. Op codes: 0 add, 1 subtract, 2 shift-left, 3 rotate-left, 4 select, 5 pack, 6 merge-high, 7 merge-low.
- R10: An op code of 8 or above, a width code of 0, 6 or 7, or a modifier code of 3 gives a zero result with out_err high.
- R11: result, out_err and out_valid change one clock after in_valid is sampled high. While in_valid is low, out_valid is low on the following cycle and result and out_err hold.
- R12: While rst_n is low, result, out_err and out_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for this cycle |
| opcode | input | 11 | Operation, width code and two modifiers |
| opnd_a | input | N | First operand |
| opnd_b | input | N | Second operand, which also supplies counts |
| opnd_c | input | N | Third operand, used by select only |
| out_valid | output | 1 | Result registered this cycle |
| result | output | N | Registered result word |
| out_err | output | 1 | Registered unsupported-opcode flag |

## Verification
The bench targets carry and borrow leaking across field boundaries with all-ones operands. A design that did not mask at field edges would corrupt the neighbouring field. Shift and rotate counts carry nonzero bits above log2(n), which would empty or misplace fields in a design that did not reduce the count mod n. Pack and merge are checked at every width with every modifier pair, where a swapped operand order or a wrong half shows up as misplaced fields. Illegal width, op and modifier codes must give a zero word with the flag set. Idle cycles must leave the registered result untouched.

// File: rtl/swar_pkg.sv
package swar_pkg;

  localparam int NUM_W    = 5;
  localparam int MAX_WLOG = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLL  = 4'd2,
    OP_ROTL = 4'd3,
    OP_SEL  = 4'd4,
    OP_PACK = 4'd5,
    OP_MRGH = 4'd6,
    OP_MRGL = 4'd7
  } op_e;

  typedef enum logic [1:0] {
    MOD_X = 2'd0,
    MOD_H = 2'd1,
    MOD_L = 2'd2
  } mod_e;

  typedef struct packed {
    logic [3:0] op;
    logic [2:0] wlog;
    logic [1:0] mod_a;
    logic [1:0] mod_b;
  } opcode_t;

  // mask of w low ones, w in 1..32
  function automatic logic [31:0] fld_mask(input int w);
    if (w >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << w) - 32'h1;
  endfunction

  // half-operand modifier on one field
  function automatic logic [31:0] fld_mod(input logic [31:0] f, input logic [1:0] m, input int w);
    int half;
    half = w / 2;
    case (m)
      MOD_H:   return (f >> half) & fld_mask(half);
      MOD_L:   return f & fld_mask(half);
      default: return f & fld_mask(w);
    endcase
  endfunction

  function automatic logic [31:0] fld_add(input logic [31:0] a, input logic [31:0] b, input int w);
    return (a + b) & fld_mask(w);
  endfunction

  function automatic logic [31:0] fld_sub(input logic [31:0] a, input logic [31:0] b, input int w);
    return (a - b) & fld_mask(w);
  endfunction

  // count mod w, w a power of two
  function automatic logic [31:0] fld_cnt(input logic [31:0] b, input int w);
    return b & 32'(w - 1);
  endfunction

  function automatic logic [31:0] fld_shl(input logic [31:0] a, input logic [31:0] b, input int w);
    return (a << fld_cnt(b, w)) & fld_mask(w);
  endfunction

  function automatic logic [31:0] fld_rotl(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] s;
    logic [31:0] am;
    s  = fld_cnt(b, w);
    am = a & fld_mask(w);
    return ((am << s) | (am >> (32'(w) - s))) & fld_mask(w);
  endfunction

  function automatic logic [31:0] fld_sel(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c, input int w);
    return ((a & b) | (~a & c)) & fld_mask(w);
  endfunction

  function automatic logic oc_legal(input opcode_t oc);
    logic ok;
    ok = (oc.op <= 4'(OP_MRGL));
    ok = ok && (oc.wlog >= 3'd1) && (oc.wlog <= 3'(MAX_WLOG));
    ok = ok && (oc.mod_a != 2'd3) && (oc.mod_b != 2'd3);
    return ok;
  endfunction

  function automatic logic op_is_reorg(input logic [3:0] op);
    return (op == OP_PACK) || (op == OP_MRGH) || (op == OP_MRGL);
  endfunction

endpackage

// File: rtl/swar_hom.sv
module swar_hom
  import swar_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 8
) (
  input  logic [N-1:0] din,
  input  logic [1:0]   mode,
  output logic [N-1:0] dout
);
  localparam int NF = N / W;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic [31:0] modded;
    assign modded = fld_mod(32'(din[i*W +: W]), mode, W);
    assign dout[i*W +: W] = W'(modded);
  end
endmodule

// File: rtl/swar_lane.sv
module swar_lane
  import swar_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 8
) (
  input  logic [N-1:0] a_m,
  input  logic [N-1:0] b_m,
  input  logic [N-1:0] c_raw,
  input  logic [3:0]   op,
  output logic [N-1:0] res
);
  localparam int NF = N / W;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic [31:0] fa, fb, fc, fr;
    assign fa = 32'(a_m[i*W +: W]);
    assign fb = 32'(b_m[i*W +: W]);
    assign fc = 32'(c_raw[i*W +: W]);
    always_comb begin
      case (op_e'(op))
        OP_ADD:  fr = fld_add(fa, fb, W);
        OP_SUB:  fr = fld_sub(fa, fb, W);
        OP_SLL:  fr = fld_shl(fa, fb, W);
        OP_ROTL: fr = fld_rotl(fa, fb, W);
        OP_SEL:  fr = fld_sel(fa, fb, fc, W);
        default: fr = '0;
      endcase
    end
    assign res[i*W +: W] = W'(fr);
  end
endmodule

// File: rtl/swar_reorg.sv
module swar_reorg
  import swar_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 8
) (
  input  logic [N-1:0] a_m,
  input  logic [N-1:0] b_m,
  input  logic [3:0]   op,
  output logic [N-1:0] res
);
  localparam int NF   = N / W;
  localparam int H    = W / 2;
  localparam int HALF = N / 2;

  logic [N-1:0] pk, mh, ml;

  // pack: A fills upper half, B the lower
  for (genvar i = 0; i < NF; i++) begin : g_pack
    assign pk[HALF + i*H +: H] = a_m[i*W +: H];
    assign pk[i*H +: H]        = b_m[i*W +: H];
  end

  // merge: interleave fields into double-width fields, A on top
  for (genvar k = 0; k < NF/2; k++) begin : g_merge
    assign mh[k*2*W +: 2*W] = {a_m[(k + NF/2)*W +: W], b_m[(k + NF/2)*W +: W]};
    assign ml[k*2*W +: 2*W] = {a_m[k*W +: W], b_m[k*W +: W]};
  end

  always_comb begin
    case (op_e'(op))
      OP_PACK: res = pk;
      OP_MRGH: res = mh;
      default: res = ml;
    endcase
  end
endmodule

// File: rtl/swar_alu.sv
module swar_alu
  import swar_pkg::*;
#(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [10:0]  opcode,
  input  logic [N-1:0] opnd_a,
  input  logic [N-1:0] opnd_b,
  input  logic [N-1:0] opnd_c,
  output logic         out_valid,
  output logic [N-1:0] result,
  output logic         out_err
);
  opcode_t oc;
  assign oc = opcode_t'(opcode);

  // named internal events
  logic         dec_ok;
  logic         is_reorg;
  logic [N-1:0] chosen;
  logic [N-1:0] next_res;

  assign dec_ok   = oc_legal(oc);
  assign is_reorg = op_is_reorg(oc.op);

  logic [N-1:0] lane_res  [NUM_W];
  logic [N-1:0] reorg_res [NUM_W];

  for (genvar k = 0; k < NUM_W; k++) begin : g_w
    localparam int W = 2 << k;
    logic [N-1:0] am, bm;

    swar_hom #(.N(N), .W(W)) u_hom_a (.din(opnd_a), .mode(oc.mod_a), .dout(am));
    swar_hom #(.N(N), .W(W)) u_hom_b (.din(opnd_b), .mode(oc.mod_b), .dout(bm));

    swar_lane #(.N(N), .W(W)) u_lane (
      .a_m(am), .b_m(bm), .c_raw(opnd_c), .op(oc.op), .res(lane_res[k])
    );

    swar_reorg #(.N(N), .W(W)) u_reorg (
      .a_m(am), .b_m(bm), .op(oc.op), .res(reorg_res[k])
    );
  end

  always_comb begin
    chosen = '0;
    for (int k = 0; k < NUM_W; k++) begin
      if (oc.wlog == 3'(k + 1)) chosen = is_reorg ? reorg_res[k] : lane_res[k];
    end
  end

  assign next_res = dec_ok ? chosen : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      out_err   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= next_res;
        out_err <= !dec_ok;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R11
  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(out_err)));  // R11
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (result == '0));  // R10
  AST_BAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode[6:4] == 3'd0 || opcode[6:4] > 3'd5)) |=> out_err);  // R9
  AST_SHL_NOCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[10:7] == 4'd2 && opcode[3:0] == 4'd0 &&
     opcode[6:4] >= 3'd1 && opcode[6:4] <= 3'd5 && opnd_b == '0)
    |=> (result == $past(opnd_a)));  // R3
  AST_SEL_ALL_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode[10:7] == 4'd4 && opcode[3:0] == 4'd0 &&
     opcode[6:4] >= 3'd1 && opcode[6:4] <= 3'd5 && (&opnd_a))
    |=> (result == $past(opnd_b)));  // R5
endmodule

// File: tb/swar_alu_bench.sv
module swar_alu_bench;
  localparam int N = 64;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [10:0]  opcode = '0;
  logic [N-1:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic         out_valid;
  logic [N-1:0] result;
  logic         out_err;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swar_alu #(.N(N)) u_swar_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .out_valid(out_valid), .result(result), .out_err(out_err)
  );

  function automatic logic [63:0] pick(logic [63:0] v, int m, int n);
    logic [63:0] hm;
    hm = (64'd1 << (n/2)) - 64'd1;
    if (m == 1) return (v >> (n/2)) & hm;
    if (m == 2) return v & hm;
    return v;
  endfunction

  // returns {err, result}
  function automatic logic [64:0] model(int op, int wl, int ma, int mb,
                                         logic [63:0] a, logic [63:0] b, logic [63:0] c);
    logic [63:0] r, mask, fa, fb, fc, s, fa2, fb2;
    int n, nf, h, j;
    r = '0;
    if (op > 7 || wl < 1 || wl > 5 || ma == 3 || mb == 3) return {1'b1, 64'd0};
    n = 1 << wl; nf = 64 / n; h = n / 2;
    mask = (64'd1 << n) - 64'd1;
    if (op <= 5) begin
      for (int i = 0; i < nf; i++) begin
        fa = pick((a >> (i*n)) & mask, ma, n);
        fb = pick((b >> (i*n)) & mask, mb, n);
        fc = (c >> (i*n)) & mask;
        s  = fb % n;
        case (op)
          0: r |= ((fa + fb) & mask) << (i*n);
          1: r |= ((fa - fb) & mask) << (i*n);
          2: r |= ((fa << s) & mask) << (i*n);
          3: r |= (((fa << s) | (fa >> (n - s))) & mask) << (i*n);
          4: r |= (((fa & fb) | (~fa & fc)) & mask) << (i*n);
          default: begin
            r |= (fa & ((64'd1 << h) - 1)) << (32 + i*h);
            r |= (fb & ((64'd1 << h) - 1)) << (i*h);
          end
        endcase
      end
    end else begin
      for (int k = 0; k < nf/2; k++) begin
        j = (op == 6) ? k + nf/2 : k;
        fa2 = pick((a >> (j*n)) & mask, ma, n);
        fb2 = pick((b >> (j*n)) & mask, mb, n);
        r |= ((fa2 << n) | fb2) << (k*2*n);
      end
    end
    return {1'b0, r};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(int op, int wl, int ma, int mb,
                        logic [63:0] a, logic [63:0] b, logic [63:0] c, string tag);
    logic [64:0] exp;
    exp = model(op, wl, ma, mb, a, b, c);
    @(negedge clk);
    opcode = {4'(op), 3'(wl), 2'(ma), 2'(mb)};
    opnd_a = a; opnd_b = b; opnd_c = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_err, result} == exp, tag, {out_err, result}, exp);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, c, held;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(result == '0 && !out_err && !out_valid, "R12",
          {out_err, result}, 65'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 fixed case: width 8, A upper half, B lower half, add
    run_op(0, 3, 1, 2, 64'h0000_0000_0000_A5F3, 64'h0000_0000_0000_3C7E, '0, "R6");
    // R9 extremes: width 2 and width 32 subtract
    run_op(1, 1, 0, 0, 64'h5555_5555_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R9");
    run_op(1, 5, 0, 0, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, '0, "R9");

    // main sweep
    for (int op = 0; op < 8; op++)
      for (int wl = 1; wl <= 5; wl++)
        for (int ma = 0; ma < 3; ma++)
          for (int mb = 0; mb < 3; mb++)
            for (int v = 0; v < 4; v++) begin
              a = rnd64(); b = rnd64(); c = rnd64();
              if (v == 1) begin a = '1; b = '1; end
              if (v == 3) b = 64'hF0F0_F0F0_F0F0_F0F0;
              run_op(op, wl, ma, mb, a, b, c, tag_of(op));
            end

    // R10 illegal encodings
    for (int op = 8; op < 16; op++) run_op(op, 3, 0, 0, rnd64(), rnd64(), rnd64(), "R10");
    run_op(0, 0, 0, 0, rnd64(), rnd64(), rnd64(), "R10");
    run_op(0, 6, 0, 0, rnd64(), rnd64(), rnd64(), "R10");
    run_op(2, 7, 0, 0, rnd64(), rnd64(), rnd64(), "R10");
    run_op(0, 3, 3, 0, rnd64(), rnd64(), rnd64(), "R10");
    run_op(5, 3, 0, 3, rnd64(), rnd64(), rnd64(), "R10");

    // R11 idle cycles hold result
    run_op(0, 4, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, '0, "R11");
    held = result;
    @(negedge clk);
    opcode = {4'd1, 3'd2, 4'd0};
    opnd_a = rnd64(); opnd_b = rnd64();
    repeat (2) @(negedge clk);
    check(!out_valid && result == held && !out_err, "R11",
          {out_err, result}, {1'b0, held});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule